// File: doc/BRIEF.md
# Validity-Tagged CAM Compare Engine

This block is a small content-addressable memory. Each entry stores a data word and a two-bit validity tag. A 16-bit instruction word drives it. The decoder recognises three kinds of word: a compare, a tag-control command and a no-operation. Any word it does not recognise is ignored.

A compare looks only at the entries whose tag equals a chosen state. For the valid, skip and random states, those entries are matched against a comparand register, optionally through a mask. For the empty state, only the tags are matched and the data is not looked at. One clock later the block reports a hit flag, a multiple-hit flag and the lowest matching index, which serves as the highest-priority address.

The tag-control command rewrites the tag of one entry. That entry is chosen in one of three ways: the address register, the last highest-priority address, or a direct address. When the address register or a direct address is used, the address register then steps up or down, as a small control register selects. Entry data and tags are loaded, and read back, through a plain direct port.

Top module: `vcam_engine`

## Requirements
- R1: After reset every tag reads 00 (empty), the hit flag, multiple-hit flag and result address are 0, and the address register is 0. The control, comparand and mask registers are also 0.
- R2: When `wr_en` is high at a clock edge, the entry at `wr_addr` takes `wr_data` and `wr_tag`. `rd_data` and `rd_tag` show the entry at `rd_addr` combinationally.
- R3: The compare word is 0x0500 | s, with s in 1..3 (1 valid, 2 skip, 3 random). It hits the entries whose tag equals s and whose data equals the comparand. When control bit 2 is set, comparand bits whose mask bit is 1 are excluded.
- R4: The compare word 0x0500 (empty mode) hits every entry whose tag is 00, whatever its data and whatever the comparand or mask.
- R5: A compare updates `cmp_hit`, `cmp_multi` (two or more hits) and `cmp_addr` (the lowest hitting index, 0 when there is no hit) at the clock edge that samples it. These values hold until the next compare.
- R6: The tag-control word is 0x0400 | f<<11 | t<<3 | s, with s in 0..3. It writes tag s into one target entry. The target is chosen as follows:
  - the address register when f=0 and t=0;
  - the last `cmp_addr` when f=0 and t=1, and then only if `cmp_hit` is 1;
  - `dir_addr` when f=1 or t>=2.
- R7: After a tag-control command that targets the address register or a direct address, the address register steps from that address. Control bits [1:0] select the step: 01 is +1 and 10 is -1, both wrapping within the depth; any other value means no step. A command that targets the highest-priority address leaves the address register unchanged.
- R8: The no-operation 0x0300 changes no state. So does any word outside R3, R4 and R6, including compare or tag-control words with bit 2 set.
- R9: A port write and an instruction may fall in the same cycle. A compare in that cycle sees the contents from before the write. When a tag-control command hits the entry being port-written, the command's tag wins and the port's data is still stored.
- R10: A load of the comparand, mask or control register takes effect only for instructions in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Direct entry write strobe |
| wr_addr | input | AW | Entry index to write |
| wr_data | input | DW | Data word to write |
| wr_tag | input | 2 | Tag to write |
| rd_addr | input | AW | Entry index to read |
| rd_data | output | DW | Data of the entry read |
| rd_tag | output | 2 | Tag of the entry read |
| cmpd_we | input | 1 | Comparand register load |
| cmpd_in | input | DW | New comparand |
| mask_we | input | 1 | Mask register load |
| mask_in | input | DW | New mask (1 = bit excluded) |
| ctl_we | input | 1 | Control register load |
| ctl_in | input | 3 | Bit 2 mask enable; bits [1:0] step mode |
| instr_valid | input | 1 | Instruction strobe |
| instr | input | 16 | Instruction word |
| dir_addr | input | AW | Direct target address for tag control |
| cmp_hit | output | 1 | Last compare found a hit |
| cmp_multi | output | 1 | Last compare found two or more hits |
| cmp_addr | output | AW | Lowest hitting index of the last compare |
| areg | output | AW | Address register |

## Verification
Two functions can collide in one cycle: a direct-port write and an instruction. The bench provokes this in two ways. First, it issues a valid-state compare in the very cycle that the port turns entry 0 valid with matching data. The result must still point at index 2, and only the next compare may report index 0. Second, it issues a direct tag-control to entry 4 while the port writes that entry with a different tag. The read port must then show the command's tag and the port's data. A comparand load in the same cycle as a compare is judged the same way: the result must reflect the old comparand.

// File: rtl/vcam_pkg.sv
package vcam_pkg;

    typedef enum logic [1:0] {
        TAG_EMPTY  = 2'b00,
        TAG_VALID  = 2'b01,
        TAG_SKIP   = 2'b10,
        TAG_RANDOM = 2'b11
    } tag_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_CMP  = 2'd1,
        OP_TAG  = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        TGT_AREG   = 2'd0,
        TGT_PRIO   = 2'd1,
        TGT_DIRECT = 2'd2
    } tgt_e;

    typedef struct packed {
        op_e  op;
        tag_e state;
        tgt_e tgt;
    } cmd_t;

    localparam logic [1:0] STEP_UP   = 2'b01;
    localparam logic [1:0] STEP_DOWN = 2'b10;

endpackage

// File: rtl/vcam_decode.sv
module vcam_decode
    import vcam_pkg::*;
(
    input  logic        instr_valid,
    input  logic [15:0] instr,
    output cmd_t        cmd
);

    always_comb begin
        cmd.op    = OP_NONE;
        cmd.state = tag_e'(instr[1:0]);
        cmd.tgt   = TGT_AREG;
        if (instr_valid && !instr[2]) begin
            if (instr[15:3] == 13'h00A0) begin
                cmd.op = OP_CMP;
            end else if (instr[15:12] == 4'h0 && instr[10:6] == 5'b10000) begin
                cmd.op = OP_TAG;
                if (instr[11] || instr[5:4] != 2'b00) begin
                    cmd.tgt = TGT_DIRECT;
                end else if (instr[3]) begin
                    cmd.tgt = TGT_PRIO;
                end else begin
                    cmd.tgt = TGT_AREG;
                end
            end
        end
    end

endmodule

// File: rtl/vcam_match.sv
module vcam_match
    import vcam_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][1:0]    tags,
    input  logic [DEPTH-1:0][DW-1:0] data,
    input  logic [DW-1:0]            cmpd,
    input  logic [DW-1:0]            mask,
    input  logic                     mask_en,
    input  tag_e                     state,
    output logic                     hit_any,
    output logic                     hit_multi,
    output logic [AW-1:0]            hit_idx
);

    logic [DW-1:0]    care;
    logic [DEPTH-1:0] hit;

    assign care = mask_en ? ~mask : '1;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign hit[i] = (tags[i] == state) &&
                        ((state == TAG_EMPTY) || (((data[i] ^ cmpd) & care) == '0));
    end

    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit[i]) hit_idx = AW'(i);
        end
    end

    assign hit_any   = |hit;
    assign hit_multi = (hit & (hit - 1'b1)) != '0;

endmodule

// File: rtl/vcam_engine.sv
module vcam_engine
    import vcam_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    wr_tag,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [1:0]    rd_tag,
    input  logic          cmpd_we,
    input  logic [DW-1:0] cmpd_in,
    input  logic          mask_we,
    input  logic [DW-1:0] mask_in,
    input  logic          ctl_we,
    input  logic [2:0]    ctl_in,
    input  logic          instr_valid,
    input  logic [15:0]   instr,
    input  logic [AW-1:0] dir_addr,
    output logic          cmp_hit,
    output logic          cmp_multi,
    output logic [AW-1:0] cmp_addr,
    output logic [AW-1:0] areg
);

    typedef struct packed {
        logic [DEPTH-1:0][1:0]    tag;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [AW-1:0]            ar;
        logic [DW-1:0]            cmpd;
        logic [DW-1:0]            mask;
        logic [2:0]               ctl;
        logic                     hit;
        logic                     multi;
        logic [AW-1:0]            hpa;
    } state_t;

    state_t        s_d, s_q;
    cmd_t          cmd;
    logic          m_any, m_multi;
    logic [AW-1:0] m_idx;
    logic [AW-1:0] tgt, base;
    logic          tgt_ok;

    vcam_decode u_dec (
        .instr_valid (instr_valid),
        .instr       (instr),
        .cmd         (cmd)
    );

    vcam_match #(.DEPTH(DEPTH), .DW(DW)) u_match (
        .tags      (s_q.tag),
        .data      (s_q.data),
        .cmpd      (s_q.cmpd),
        .mask      (s_q.mask),
        .mask_en   (s_q.ctl[2]),
        .state     (cmd.state),
        .hit_any   (m_any),
        .hit_multi (m_multi),
        .hit_idx   (m_idx)
    );

    always_comb begin
        s_d    = s_q;
        tgt    = s_q.ar;
        base   = s_q.ar;
        tgt_ok = 1'b1;

        // port write first so a same-cycle tag command overrides its tag
        if (wr_en) begin
            s_d.data[wr_addr] = wr_data;
            s_d.tag[wr_addr]  = wr_tag;
        end
        if (cmpd_we) s_d.cmpd = cmpd_in;
        if (mask_we) s_d.mask = mask_in;
        if (ctl_we)  s_d.ctl  = ctl_in;

        case (cmd.op)
            OP_CMP: begin
                s_d.hit   = m_any;
                s_d.multi = m_multi;
                s_d.hpa   = m_idx;
            end
            OP_TAG: begin
                case (cmd.tgt)
                    TGT_DIRECT: begin
                        tgt  = dir_addr;
                        base = dir_addr;
                    end
                    TGT_PRIO: begin
                        tgt    = s_q.hpa;
                        tgt_ok = s_q.hit;
                    end
                    default: ;
                endcase
                if (tgt_ok) s_d.tag[tgt] = cmd.state;
                if (cmd.tgt != TGT_PRIO) begin
                    case (s_q.ctl[1:0])
                        STEP_UP:   s_d.ar = (base == AW'(DEPTH - 1)) ? '0 : base + 1'b1;
                        STEP_DOWN: s_d.ar = (base == '0) ? AW'(DEPTH - 1) : base - 1'b1;
                        default:   s_d.ar = base;
                    endcase
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data   = s_q.data[rd_addr];
    assign rd_tag    = s_q.tag[rd_addr];
    assign cmp_hit   = s_q.hit;
    assign cmp_multi = s_q.multi;
    assign cmp_addr  = s_q.hpa;
    assign areg      = s_q.ar;

endmodule

// File: rtl/vcam_engine_chk.sv
module vcam_engine_chk #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          instr_valid,
    input logic [15:2]   instr_hi,
    input logic          cmp_hit,
    input logic          cmp_multi,
    input logic [AW-1:0] cmp_addr,
    input logic [AW-1:0] areg,
    input logic          m_any
);

    logic is_cmp, is_tag, is_tag_prio;

    assign is_cmp      = instr_valid && instr_hi[15:3] == 13'h00A0 && !instr_hi[2];
    assign is_tag      = instr_valid && !instr_hi[2] && instr_hi[15:12] == 4'h0 &&
                         instr_hi[10:6] == 5'b10000;
    assign is_tag_prio = is_tag && !instr_hi[11] && instr_hi[5:3] == 3'b001;

    AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_multi |-> cmp_hit); // R5

    AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_hit |-> cmp_addr == '0); // R5

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !is_cmp |=> $stable({cmp_hit, cmp_multi, cmp_addr})); // R5

    AST_CMP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |=> cmp_hit == $past(m_any)); // R5

    AST_AREG_ONLY_BY_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        !is_tag |=> $stable(areg)); // R8

    AST_PRIO_TGT_HOLDS_AREG: assert property (@(posedge clk) disable iff (!rst_n)
        is_tag_prio |=> $stable(areg)); // R7

endmodule

bind vcam_engine vcam_engine_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_hi    (instr[15:2]),
    .cmp_hit     (cmp_hit),
    .cmp_multi   (cmp_multi),
    .cmp_addr    (cmp_addr),
    .areg        (areg),
    .m_any       (m_any)
);

// File: tb/vcam_engine_bench.sv
module vcam_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int DW    = 64;
    localparam int AW    = 4;
    localparam logic [DW-1:0] DA = 64'hDEAD_BEEF_0123_4567;
    localparam logic [DW-1:0] DB = 64'h0F0F_0000_FFFF_1234;

    // {instr[15:0], dir[3:0], hit, multi, addr[3:0], areg[3:0]}
    localparam logic [29:0] VEC [0:15] = '{
        {16'h0501, 4'd0,  1'b1, 1'b1, 4'd2, 4'd0},   // R3 valid
        {16'h0503, 4'd0,  1'b1, 1'b0, 4'd9, 4'd0},   // R3 random
        {16'h0502, 4'd0,  1'b0, 1'b0, 4'd0, 4'd0},   // R3 skip, data differs
        {16'h0500, 4'd0,  1'b1, 1'b1, 4'd0, 4'd0},   // R4 empty
        {16'h0413, 4'd0,  1'b1, 1'b1, 4'd0, 4'd1},   // R6 direct, R7 step
        {16'h0503, 4'd0,  1'b1, 1'b0, 4'd9, 4'd1},
        {16'h0408, 4'd0,  1'b1, 1'b0, 4'd9, 4'd1},   // R6 prio target
        {16'h0503, 4'd0,  1'b0, 1'b0, 4'd0, 4'd1},
        {16'h0401, 4'd0,  1'b0, 1'b0, 4'd0, 4'd2},   // R6 areg target
        {16'h0409, 4'd0,  1'b0, 1'b0, 4'd0, 4'd2},   // prio target, no hit
        {16'h0300, 4'd0,  1'b0, 1'b0, 4'd0, 4'd2},   // R8 nop
        {16'h0C02, 4'd12, 1'b0, 1'b0, 4'd0, 4'd13},  // flag forces direct
        {16'h0502, 4'd0,  1'b0, 1'b0, 4'd0, 4'd13},
        {16'h0501, 4'd0,  1'b1, 1'b1, 4'd2, 4'd13},
        {16'h0504, 4'd0,  1'b1, 1'b1, 4'd2, 4'd13},  // R8 bit 2 set
        {16'h0500, 4'd0,  1'b1, 1'b1, 4'd3, 4'd13}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    wr_tag = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [1:0]    rd_tag;
    logic          cmpd_we = 1'b0;
    logic [DW-1:0] cmpd_in = '0;
    logic          mask_we = 1'b0;
    logic [DW-1:0] mask_in = '0;
    logic          ctl_we = 1'b0;
    logic [2:0]    ctl_in = '0;
    logic          instr_valid = 1'b0;
    logic [15:0]   instr = '0;
    logic [AW-1:0] dir_addr = '0;
    logic          cmp_hit, cmp_multi;
    logic [AW-1:0] cmp_addr, areg;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vcam_engine #(.DEPTH(DEPTH), .DW(DW)) u_vcam_engine (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic result_is(input string req, input logic [9:0] exp);
        logic [9:0] act;
        act = {cmp_hit, cmp_multi, cmp_addr, areg};
        check(act == exp, req, 64'(act), 64'(exp));
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [1:0] t);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_tag = t;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_instr(input logic [15:0] i, input logic [AW-1:0] d);
        @(negedge clk);
        instr_valid = 1'b1; instr = i; dir_addr = d;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic set_regs(input logic [2:0] c, input logic [DW-1:0] cm,
                            input logic [DW-1:0] mk);
        @(negedge clk);
        ctl_we = 1'b1; ctl_in = c; cmpd_we = 1'b1; cmpd_in = cm;
        mask_we = 1'b1; mask_in = mk;
        @(negedge clk);
        ctl_we = 1'b0; cmpd_we = 1'b0; mask_we = 1'b0;
    endtask

    task automatic tag_is(input string req, input logic [AW-1:0] a,
                          input logic [1:0] exp);
        rd_addr = a;
        #1;
        check(rd_tag == exp, req, 64'(rd_tag), 64'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        result_is("R1 result and areg", 10'd0);
        begin
            logic all_empty;
            all_empty = 1'b1;
            for (int k = 0; k < DEPTH; k++) begin
                rd_addr = AW'(k);
                #1;
                if (rd_tag != 2'b00) all_empty = 1'b0;
            end
            check(all_empty, "R1 tags empty", 64'(all_empty), 64'd1);
        end

        // R2 direct port
        do_write(4'd2,  DA, 2'b01);
        do_write(4'd5,  DA, 2'b01);
        do_write(4'd7,  DB, 2'b10);
        do_write(4'd9,  DA, 2'b11);
        do_write(4'd11, DB, 2'b01);
        rd_addr = 4'd7;
        #1;
        check(rd_data == DB && rd_tag == 2'b10, "R2 read back",
              {rd_data[61:0], rd_tag}, {DB[61:0], 2'b10});
        set_regs(3'b001, DA, '0);

        for (int k = 0; k < 16; k++) begin
            do_instr(VEC[k][29:14], VEC[k][13:10]);
            result_is($sformatf("R3 R4 R5 R6 R7 R8 vector %0d", k), VEC[k][9:0]);
        end

        tag_is("R6 prio target without hit left entry 0", 4'd0, 2'b11);
        tag_is("R6 direct via flag", 4'd12, 2'b10);
        tag_is("R6 prio target wrote entry 9", 4'd9, 2'b00);

        // R3 mask, R10 load timing
        set_regs(3'b001, DB ^ 64'hFF, '0);
        do_instr(16'h0502, '0);
        result_is("R3 unmasked miss", {1'b0, 1'b0, 4'd0, 4'd13});
        set_regs(3'b101, DB ^ 64'hFF, 64'hFF);
        do_instr(16'h0502, '0);
        result_is("R3 masked hit", {1'b1, 1'b0, 4'd7, 4'd13});
        @(negedge clk);
        cmpd_we = 1'b1; cmpd_in = DA; instr_valid = 1'b1; instr = 16'h0502;
        @(negedge clk);
        cmpd_we = 1'b0; instr_valid = 1'b0;
        result_is("R10 compare uses old comparand", {1'b1, 1'b0, 4'd7, 4'd13});
        do_instr(16'h0502, '0);
        result_is("R10 new comparand in effect", {1'b0, 1'b0, 4'd0, 4'd13});

        // R7 step down wraps
        set_regs(3'b010, DA, '0);
        do_instr(16'h0413, 4'd0);
        result_is("R7 step down wrap", {1'b0, 1'b0, 4'd0, 4'd15});

        // R9 same-cycle collisions
        set_regs(3'b001, DA, '0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = DA; wr_tag = 2'b01;
        instr_valid = 1'b1; instr = 16'h0501;
        @(negedge clk);
        wr_en = 1'b0; instr_valid = 1'b0;
        result_is("R9 compare sees pre-write", {1'b1, 1'b1, 4'd2, 4'd15});
        do_instr(16'h0501, '0);
        result_is("R9 next compare sees write", {1'b1, 1'b1, 4'd0, 4'd15});
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd4; wr_data = DB; wr_tag = 2'b01;
        instr_valid = 1'b1; instr = 16'h0412; dir_addr = 4'd4;
        @(negedge clk);
        wr_en = 1'b0; instr_valid = 1'b0;
        tag_is("R9 tag command wins", 4'd4, 2'b10);
        check(rd_data == DB, "R9 port data kept", rd_data, DB);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule